// File: doc/BRIEF.md
# Page Table Address Translator

This block turns a processor virtual address into a physical address by fetching one page table entry from memory. The virtual address is split into a virtual page number (upper bits) and a byte offset within the page (lower bits). The entry is read from a word address computed from a base register plus the page number scaled by the entry size. The block then checks the entry's presence and permission bits. If they allow the access, it returns the frame number joined with the untouched offset. If they do not, it returns a fault code in place of an address.

Only one translation is in flight at a time. A request is accepted with a valid/ready handshake. The memory side is a single-word read port: a one-cycle read strobe goes out, and the entry comes back after any number of cycles, marked by a data-valid strobe. The table base is loaded through a small configuration port. Its value is captured when each request is accepted.

Top module: `pt_xlate`

## Requirements
- R1: After synchronous reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd` is 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. In the following cycle, `mem_rd` is 1 for exactly one cycle and `mem_addr` equals base + page_number*4, taken modulo 2^32. `mem_addr` then holds steady until the entry returns.
- R3: A clock edge with `cfg_we`=1 loads `cfg_base` into the base register. Each translation uses the base value held at its acceptance edge. A base write while a translation is in flight does not change that translation's `mem_addr`.
- R4: Entry word layout: bit 31 is the present flag, bit 30 is read permission, bit 29 is write permission, and bits [PFN_W-1:0] hold the frame number.
- R5: When the entry is present and the access is permitted, the response has `rsp_fault`=0, `rsp_code`=0 and `rsp_paddr` = {frame, offset}.
- R6: When the present flag is 0, the response has `rsp_fault`=1 and `rsp_code`=1 whatever the permission bits, and `rsp_paddr`=0.
- R7: A present entry with a write request (`req_write`=1) and write permission 0 gives `rsp_code`=2. A present entry with a read request and read permission 0 gives `rsp_code`=3. Both cases have `rsp_fault`=1 and `rsp_paddr`=0.
- R8: `rsp_valid` is 1 for exactly one cycle: the cycle after the edge at which `mem_rvalid` is sampled 1 while the block waits for the entry. The read latency may be any number of cycles.
- R9: `req_ready` is 0 from the acceptance edge through the response cycle. It returns to 1 the cycle after the response, and no request is taken in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Base register write enable |
| cfg_base | input | 32 | New table base byte address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VPN_W+OFF_W (15) | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Response strobe |
| rsp_fault | output | 1 | Response is a fault |
| rsp_code | output | 2 | 0 ok, 1 not present, 2 write denied, 3 read denied |
| rsp_paddr | output | PFN_W+OFF_W (13) | Physical address (0 on fault) |
| mem_rd | output | 1 | Entry read strobe |
| mem_addr | output | 32 | Entry byte address |
| mem_rvalid | input | 1 | Entry data valid |
| mem_rdata | input | 32 | Entry word |

## Verification
The bench builds the block with its defaults: 5-bit page numbers, 3-bit frames and 10-bit offsets. That makes the whole page table small enough to sweep. For three table bases, one of them chosen so the entry address wraps past 2^32, every page is translated both as a read and as a write. The bench generates the entries arithmetically so that every combination of present and permission bits occurs. It also varies the memory latency from zero to three wait cycles. One translation rewrites the base while it is in flight, which shows that the captured base is the one used.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_ABSENT  = 2'd1,
        FLT_NOWRITE = 2'd2,
        FLT_NOREAD  = 2'd3
    } flt_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_RESP
    } st_e;

    typedef struct packed {
        logic present;
        logic rd_ok;
        logic wr_ok;
    } pte_flags_t;

    function automatic flt_e judge(pte_flags_t f, logic is_wr);
        if (!f.present)            return FLT_ABSENT;
        else if (is_wr && !f.wr_ok) return FLT_NOWRITE;
        else if (!is_wr && !f.rd_ok) return FLT_NOREAD;
        else                        return FLT_NONE;
    endfunction

endpackage

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
    import ptx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic mem_rvalid,
    output logic req_ready,
    output logic accept,
    output logic mem_rd,
    output logic take_entry,
    output logic rsp_valid
);
    st_e st;

    assign req_ready  = (st == ST_IDLE);
    assign accept     = req_ready && req_valid;
    assign mem_rd     = (st == ST_FETCH);
    assign take_entry = (st == ST_WAIT) && mem_rvalid;
    assign rsp_valid  = (st == ST_RESP);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE:  if (req_valid) st <= ST_FETCH;
                ST_FETCH: st <= ST_WAIT;
                ST_WAIT:  if (mem_rvalid) st <= ST_RESP;
                ST_RESP:  st <= ST_IDLE;
                default:  st <= ST_IDLE;
            endcase
        end
    end

    // R2
    strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> (mem_rd ##1 !mem_rd));

    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        take_entry |=> (rsp_valid ##1 !rsp_valid));

    // R9
    ready_back_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

endmodule

// File: rtl/ptx_agen.sv
module ptx_agen #(
    parameter int VPN_W       = 5,
    parameter int ADDR_W      = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              load,
    input  logic              hold,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] scaled;

    assign scaled = ADDR_W'(vpn) << SHIFT;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            mem_addr <= '0;
        end else begin
            if (cfg_we) base_q <= cfg_base;
            if (load)   mem_addr <= base_q + scaled;
        end
    end

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(mem_addr));

endmodule

// File: rtl/ptx_check.sv
module ptx_check
    import ptx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int PFN_W  = 3
) (
    input  logic [DATA_W-1:0] pte,
    input  logic              is_wr,
    output flt_e              code,
    output logic [PFN_W-1:0]  pfn
);
    pte_flags_t flags;

    assign flags = '{present: pte[DATA_W-1], rd_ok: pte[DATA_W-2], wr_ok: pte[DATA_W-3]};
    assign code  = judge(flags, is_wr);
    assign pfn   = pte[PFN_W-1:0];

    // R6
    always_comb begin
        absent_first_chk: assert (pte[DATA_W-1] || code == FLT_ABSENT);
    end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
    import ptx_pkg::*;
#(
    parameter int VPN_W       = 5,
    parameter int PFN_W       = 3,
    parameter int OFF_W       = 10,
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_base,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr,
    input  logic                   req_write,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [1:0]             rsp_code,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic                   mem_rd,
    output logic [ADDR_W-1:0]      mem_addr,
    input  logic                   mem_rvalid,
    input  logic [DATA_W-1:0]      mem_rdata
);
    localparam int PA_W = PFN_W + OFF_W;

    logic             accept;
    logic             take_entry;
    logic [OFF_W-1:0] off_q;
    logic             wr_q;
    flt_e             code_c;
    logic [PFN_W-1:0] pfn_c;
    logic             waiting;

    assign waiting = !req_ready && !rsp_valid && !mem_rd;

    ptx_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .mem_rvalid (mem_rvalid),
        .req_ready  (req_ready),
        .accept     (accept),
        .mem_rd     (mem_rd),
        .take_entry (take_entry),
        .rsp_valid  (rsp_valid)
    );

    ptx_agen #(
        .VPN_W       (VPN_W),
        .ADDR_W      (ADDR_W),
        .ENTRY_BYTES (ENTRY_BYTES)
    ) u_agen (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_base (cfg_base),
        .load     (accept),
        .hold     (waiting && !take_entry),
        .vpn      (req_vaddr[VPN_W+OFF_W-1:OFF_W]),
        .mem_addr (mem_addr)
    );

    ptx_check #(
        .DATA_W (DATA_W),
        .PFN_W  (PFN_W)
    ) u_check (
        .pte   (mem_rdata),
        .is_wr (wr_q),
        .code  (code_c),
        .pfn   (pfn_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q     <= '0;
            wr_q      <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_code  <= FLT_NONE;
            rsp_paddr <= '0;
        end else begin
            if (accept) begin
                off_q <= req_vaddr[OFF_W-1:0];
                wr_q  <= req_write;
            end
            if (take_entry) begin
                rsp_code  <= code_c;
                rsp_fault <= (code_c != FLT_NONE);
                rsp_paddr <= (code_c == FLT_NONE) ? {pfn_c, off_q} : PA_W'(0);
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (req_ready && !rsp_valid && !mem_rd));

    // R7
    fault_code_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_fault == (rsp_code != 2'd0)));

    // R6
    fault_zero_pa_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0));

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

endmodule

// File: tb/pt_xlate_tb.sv
`timescale 1ns/1ps
module pt_xlate_tb;
    localparam int VPN_W = 5;
    localparam int PFN_W = 3;
    localparam int OFF_W = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [31:0] cfg_base;
    logic        req_valid;
    logic        req_ready;
    logic [VPN_W+OFF_W-1:0] req_vaddr;
    logic        req_write;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [1:0]  rsp_code;
    logic [PFN_W+OFF_W-1:0] rsp_paddr;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pt_xlate u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_base(input logic [31:0] b);
        @(negedge clk);
        cfg_we = 1'b1; cfg_base = b;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one translation; entry and latency chosen by caller
    task automatic xlate(input int v, input int off, input bit wr, input logic [31:0] base,
                         input logic [31:0] pte, input int lat, input bit poke_base);
        logic [31:0] exp_addr;
        int          exp_code;
        logic [PFN_W+OFF_W-1:0] exp_pa;
        exp_addr = base + 32'(v) * 32'd4;
        if (!pte[31])              exp_code = 1;
        else if (wr && !pte[29])   exp_code = 2;
        else if (!wr && !pte[30])  exp_code = 3;
        else                       exp_code = 0;
        exp_pa = (exp_code == 0) ? {pte[PFN_W-1:0], OFF_W'(off)} : '0;

        @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready idle", req_ready, 1);
        req_valid = 1'b1; req_vaddr = {VPN_W'(v), OFF_W'(off)}; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_rd == 1'b1, "R2 strobe", mem_rd, 1);
        chk(mem_addr == exp_addr, "R2 entry address", mem_addr, exp_addr);
        chk(req_ready == 1'b0, "R9 busy", req_ready, 0);
        if (poke_base) begin cfg_we = 1'b1; cfg_base = ~base; end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            cfg_we = 1'b0;
            chk(mem_rd == 1'b0 && rsp_valid == 1'b0, "R8 waiting", {mem_rd, rsp_valid}, 0);
            chk(mem_addr == exp_addr, "R3 address held", mem_addr, exp_addr);
        end
        @(negedge clk);
        cfg_we = 1'b0;
        mem_rvalid = 1'b1; mem_rdata = pte;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk(rsp_valid == 1'b1, "R8 response", rsp_valid, 1);
        chk(rsp_code == 2'(exp_code),
            exp_code == 0 ? "R5 code" : exp_code == 1 ? "R6 absent" : "R7 rights",
            rsp_code, exp_code);
        chk(rsp_fault == (exp_code != 0), "R7 fault flag", rsp_fault, exp_code != 0);
        chk(rsp_paddr == exp_pa, exp_code == 0 ? "R5 paddr" : "R6 zero paddr", rsp_paddr, exp_pa);
        chk(req_ready == 1'b0, "R9 busy in response", req_ready, 0);
        @(negedge clk);
        chk(rsp_valid == 1'b0 && req_ready == 1'b1, "R8 single response", {rsp_valid, req_ready}, 1);
        if (poke_base) set_base(base);
    endtask

    initial begin
        logic [31:0] bases [3];
        bases[0] = 32'h0000_0000;
        bases[1] = 32'h0000_4000;
        bases[2] = 32'hFFFF_FFC0;
        rst = 1'b1; cfg_we = 1'b0; cfg_base = '0; req_valid = 1'b0;
        req_vaddr = '0; req_write = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd == 1'b0, "R1 reset state",
            {req_ready, rsp_valid, mem_rd}, 3'b100);
        // mem_rvalid while idle must not produce a response
        mem_rvalid = 1'b1;
        @(negedge clk);
        mem_rvalid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8 stray data ignored", rsp_valid, 0);
        for (int k = 0; k < 3; k++) begin
            set_base(bases[k]);
            for (int v = 0; v < 32; v++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] pte;
                    int s;
                    s = v + k + w;
                    // R4: bit31 present, bit30 read, bit29 write, low bits frame
                    pte = {((v + k) % 7) != 0, (s % 3) != 2, (s % 2) == 0,
                           26'h2AA_AAA8 >> 3, 3'((v * 3 + k) % 8)};
                    xlate(v, (v * 37 + k * 11 + w) % 1024, w[0], bases[k], pte,
                          (v + w) % 4, (v == 5 && w == 1));
                end
            end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule